// File: doc/BRIEF.md
# Partitioned Frame Buffer Admission Controller

This block guards the slots of a shared frame buffer. It does not hold frame data. It tracks, for each region of a partitioned buffer, how many slots are in use, and it decides where each received frame is charged. When a frame arrives, its priority and source port are not yet known, so it first takes one slot from a small temporary reserve. If that reserve is already at its programmed size, the arrival is refused at once.

When classification later returns a priority (0 to 7) and a source port (0 to 9), the temporary slot is given back. The frame is then charged to one of these regions, in order:

1. The reserve of its priority pair.
2. The shared pool.
3. The reserve of its source port.

If none of them has room, the frame is dropped. The response carries a region code and an index. The frame's owner returns the slot later with a free request that carries the same code and index.

Every region size comes from a configuration input. Three class reserves cover priorities 2&3, 4&5 and 6&7. Ten source-port reserves take their size from one of three inputs: one for ordinary ports, one for the CPU port and one for the gigabit port. A free that finds its counter empty sets a sticky error flag.

Top module: `abuf_admit`

## Requirements
- R1: While reset is low and after reset is released, `arr_ok`, `arr_nobuf`, `plc_valid`, `plc_drop`, `plc_region`, `plc_index` and `err_flag` are all 0, and every occupancy count is zero.
- R2: One cycle after `arr_valid`, exactly one of `arr_ok` or `arr_nobuf` pulses. `arr_ok` pulses, and a temporary slot is taken, when temporary occupancy is below `cfg_tmp_size`. Otherwise `arr_nobuf` pulses and nothing is taken.
- R3: A classified frame of priority 2 or 3, 4 or 5, or 6 or 7 is placed in class reserve 0, 1 or 2 respectively, if that reserve is below its size in `cfg_cls_size` (reserve k is in bits k*CNT_W upward). The response is region code 0 with index k.
- R4: A frame of priority 0 or 1, or one whose class reserve is full, is placed in the shared pool if the pool is below `cfg_shared_size`. The response is region code 1 with index 0.
- R5: If the shared pool is also full, the frame is placed in its source port's reserve. The response is region code 2 with the port number as index. Port 8 is limited by `cfg_cpu_size`, port 9 by `cfg_gig_size`, and ports 0 to 7 by `cfg_slow_size`.
- R6: If no eligible region has room, or the port number is 10 or above with the shared pool full, the frame is dropped. The response is `plc_drop`=1 with region code 3 and index 0.
- R7: One cycle after `cls_valid`, `plc_valid` pulses. Every classification releases one temporary slot, whether the frame is placed or dropped. When no classification is pending, `plc_valid`, `plc_region` and `plc_index` are 0.
- R8: A free request (`free_valid`, with `free_region` 0, 1 or 2 and `free_index`) lowers exactly the addressed counter by one, and that slot can be used again by a later placement.
- R9: A free to an empty counter, or a classification while the temporary reserve is empty, leaves the counter at zero. It sets `err_flag`, which stays 1 until reset.
- R10: When a free and a classification fall in the same cycle, the free is applied first, so the placement can use the slot just freed.
- R11: When a classification and an arrival fall in the same cycle, the arrival sees the temporary slot released by that classification.
- R12: A free with region code 3, a class index of 3 or above, or a port index of 10 or above changes no counter and does not set `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tmp_size | input | CNT_W | Temporary reserve size |
| cfg_shared_size | input | CNT_W | Shared pool size |
| cfg_cls_size | input | 3*CNT_W | Class reserve sizes, reserve k in bits k*CNT_W upward |
| cfg_slow_size | input | CNT_W | Reserve size for ports other than CPU and gigabit |
| cfg_cpu_size | input | CNT_W | Reserve size for the CPU port |
| cfg_gig_size | input | CNT_W | Reserve size for the gigabit port |
| arr_valid | input | 1 | A new frame asks for a temporary slot |
| arr_ok | output | 1 | Temporary slot granted |
| arr_nobuf | output | 1 | Arrival refused, temporary reserve full |
| cls_valid | input | 1 | Classification result for a held frame |
| cls_prio | input | 3 | Frame priority 0 to 7 |
| cls_port | input | PORT_W | Frame source port |
| plc_valid | output | 1 | Placement response |
| plc_drop | output | 1 | Frame dropped |
| plc_region | output | 2 | Region code: 0 class, 1 shared, 2 port, 3 dropped |
| plc_index | output | IDX_W | Class reserve or port index |
| free_valid | input | 1 | Return one slot |
| free_region | input | 2 | Region code of the slot returned |
| free_index | input | IDX_W | Index of the slot returned |
| err_flag | output | 1 | Sticky error: release of an empty counter |

## Verification
Three events can hit the same counters in one cycle: a free, a classification and an arrival. The bench drives an arrival together with every classification during an 80-frame sweep over all priorities and all ports. That pairing only succeeds if the arrival sees the slot just released by the classification. A separate step fills every region and then, in a single cycle, frees a class slot and classifies a frame of that class. A correct design places the frame in that reserve. A design that applies the free too late falls through to a drop.

// File: rtl/abuf_pkg.sv
package abuf_pkg;
  typedef enum logic [1:0] {
    RGN_CLASS  = 2'd0,
    RGN_SHARED = 2'd1,
    RGN_PORT   = 2'd2,
    RGN_NONE   = 2'd3
  } region_e;

  localparam int N_CLS = 3;
endpackage

// File: rtl/abuf_slot_cnt.sv
module abuf_slot_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] limit,
  input  logic             inc,
  input  logic             dec,
  output logic             avail,
  output logic             under
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_after;
  logic             dec_ok, inc_ok, cnt_en;

  always_comb begin
    dec_ok    = dec && (cnt_q != '0);
    under     = dec && (cnt_q == '0);
    cnt_after = cnt_q - CNT_W'(dec_ok);
    avail     = cnt_after < limit;
    inc_ok    = inc && avail;
    cnt_d     = cnt_after + CNT_W'(inc_ok);
    cnt_en    = dec_ok || inc_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/abuf_place.sv
module abuf_place import abuf_pkg::*; #(
  parameter int N_PORTS = 10,
  parameter int PORT_W  = 4,
  parameter int IDX_W   = 4
) (
  input  logic                req,
  input  logic [2:0]          prio,
  input  logic [PORT_W-1:0]   port,
  input  logic [N_CLS-1:0]    cls_avail,
  input  logic                sh_avail,
  input  logic [N_PORTS-1:0]  prt_avail,
  output region_e             rgn,
  output logic [IDX_W-1:0]    idx,
  output logic [N_CLS-1:0]    cls_inc,
  output logic                sh_inc,
  output logic [N_PORTS-1:0]  prt_inc
);
  logic [1:0] pair;
  logic [1:0] cidx;
  logic       port_room;

  always_comb begin
    pair      = prio[2:1];
    cidx      = pair - 2'd1;
    port_room = 1'b0;
    for (int i = 0; i < N_PORTS; i++)
      if (port == PORT_W'(i)) port_room = prt_avail[i];

    if (pair != 2'd0 && cls_avail[cidx]) begin
      rgn = RGN_CLASS;
      idx = IDX_W'(cidx);
    end else if (sh_avail) begin
      rgn = RGN_SHARED;
      idx = '0;
    end else if (port_room) begin
      rgn = RGN_PORT;
      idx = IDX_W'(port);
    end else begin
      rgn = RGN_NONE;
      idx = '0;
    end

    for (int i = 0; i < N_CLS; i++)
      cls_inc[i] = req && rgn == RGN_CLASS && idx == IDX_W'(i);
    sh_inc = req && rgn == RGN_SHARED;
    for (int i = 0; i < N_PORTS; i++)
      prt_inc[i] = req && rgn == RGN_PORT && idx == IDX_W'(i);
  end
endmodule

// File: rtl/abuf_admit.sv
module abuf_admit import abuf_pkg::*; #(
  parameter int CNT_W    = 8,
  parameter int N_PORTS  = 10,
  parameter int CPU_PORT = 8,
  parameter int GIG_PORT = 9,
  localparam int PORT_W  = $clog2(N_PORTS),
  localparam int IDX_W   = (PORT_W > 2) ? PORT_W : 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W-1:0]       cfg_tmp_size,
  input  logic [CNT_W-1:0]       cfg_shared_size,
  input  logic [N_CLS*CNT_W-1:0] cfg_cls_size,
  input  logic [CNT_W-1:0]       cfg_slow_size,
  input  logic [CNT_W-1:0]       cfg_cpu_size,
  input  logic [CNT_W-1:0]       cfg_gig_size,
  input  logic                   arr_valid,
  output logic                   arr_ok,
  output logic                   arr_nobuf,
  input  logic                   cls_valid,
  input  logic [2:0]             cls_prio,
  input  logic [PORT_W-1:0]      cls_port,
  output logic                   plc_valid,
  output logic                   plc_drop,
  output logic [1:0]             plc_region,
  output logic [IDX_W-1:0]       plc_index,
  input  logic                   free_valid,
  input  logic [1:0]             free_region,
  input  logic [IDX_W-1:0]       free_index,
  output logic                   err_flag
);
  logic               tmp_avail, tmp_under;
  logic [N_CLS-1:0]   cls_avail, cls_inc, cls_dec, cls_under;
  logic               sh_avail, sh_inc, sh_dec, sh_under;
  logic [N_PORTS-1:0] prt_avail, prt_inc, prt_dec, prt_under;
  region_e            rgn;
  logic [IDX_W-1:0]   idx;

  abuf_slot_cnt #(.CNT_W(CNT_W)) u_tmp (
    .clk(clk), .rst_n(rst_n), .limit(cfg_tmp_size),
    .inc(arr_valid), .dec(cls_valid), .avail(tmp_avail), .under(tmp_under));

  assign sh_dec = free_valid && free_region == RGN_SHARED;
  abuf_slot_cnt #(.CNT_W(CNT_W)) u_shared (
    .clk(clk), .rst_n(rst_n), .limit(cfg_shared_size),
    .inc(sh_inc), .dec(sh_dec), .avail(sh_avail), .under(sh_under));

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    assign cls_dec[c] = free_valid && free_region == RGN_CLASS && free_index == IDX_W'(c);
    abuf_slot_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .limit(cfg_cls_size[c*CNT_W +: CNT_W]),
      .inc(cls_inc[c]), .dec(cls_dec[c]), .avail(cls_avail[c]), .under(cls_under[c]));
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_prt
    logic [CNT_W-1:0] lim;
    if (p == CPU_PORT)      begin : g_cpu  assign lim = cfg_cpu_size;  end
    else if (p == GIG_PORT) begin : g_gig  assign lim = cfg_gig_size;  end
    else                    begin : g_slow assign lim = cfg_slow_size; end
    assign prt_dec[p] = free_valid && free_region == RGN_PORT && free_index == IDX_W'(p);
    abuf_slot_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .limit(lim),
      .inc(prt_inc[p]), .dec(prt_dec[p]), .avail(prt_avail[p]), .under(prt_under[p]));
  end

  abuf_place #(.N_PORTS(N_PORTS), .PORT_W(PORT_W), .IDX_W(IDX_W)) u_place (
    .req(cls_valid), .prio(cls_prio), .port(cls_port),
    .cls_avail(cls_avail), .sh_avail(sh_avail), .prt_avail(prt_avail),
    .rgn(rgn), .idx(idx), .cls_inc(cls_inc), .sh_inc(sh_inc), .prt_inc(prt_inc));

  logic             arr_ok_d, arr_nobuf_d, plc_valid_d, plc_drop_d, err_d;
  logic [1:0]       plc_region_d;
  logic [IDX_W-1:0] plc_index_d;

  always_comb begin
    arr_ok_d     = arr_valid && tmp_avail;
    arr_nobuf_d  = arr_valid && !tmp_avail;
    plc_valid_d  = cls_valid;
    plc_drop_d   = cls_valid && rgn == RGN_NONE;
    plc_region_d = cls_valid ? rgn : 2'd0;
    plc_index_d  = cls_valid ? idx : '0;
    err_d        = err_flag || tmp_under || sh_under || (|cls_under) || (|prt_under);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_ok     <= 1'b0;
      arr_nobuf  <= 1'b0;
      plc_valid  <= 1'b0;
      plc_drop   <= 1'b0;
      plc_region <= 2'd0;
      plc_index  <= '0;
      err_flag   <= 1'b0;
    end else begin
      arr_ok     <= arr_ok_d;
      arr_nobuf  <= arr_nobuf_d;
      plc_valid  <= plc_valid_d;
      plc_drop   <= plc_drop_d;
      plc_region <= plc_region_d;
      plc_index  <= plc_index_d;
      err_flag   <= err_d;
    end
  end
endmodule

// File: rtl/abuf_admit_chk.sv
module abuf_admit_chk #(
  parameter int PORT_W = 4,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arr_valid,
  input logic              arr_ok,
  input logic              arr_nobuf,
  input logic              cls_valid,
  input logic [2:0]        cls_prio,
  input logic [PORT_W-1:0] cls_port,
  input logic              plc_valid,
  input logic              plc_drop,
  input logic [1:0]        plc_region,
  input logic [IDX_W-1:0]  plc_index,
  input logic              err_flag
);
  logic [1:0] pair;
  assign pair = cls_prio[2:1];

  assert_arr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_ok && arr_nobuf));
  assert_arr_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |=> (arr_ok || arr_nobuf));
  assert_arr_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_valid |=> !(arr_ok || arr_nobuf));
  assert_plc_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |=> plc_valid);
  assert_plc_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_valid |=> !plc_valid);
  assert_cls_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (plc_valid && !plc_drop && plc_region == 2'd0) |->
      ($past(pair) != 2'd0 && plc_index == IDX_W'($past(pair) - 2'd1)));
  assert_shared_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (plc_valid && plc_region == 2'd1) |-> (plc_index == '0 && !plc_drop));
  assert_port_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (plc_valid && plc_region == 2'd2) |-> plc_index == IDX_W'($past(cls_port)));
  assert_drop_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (plc_valid && plc_drop) |-> (plc_region == 2'd3 && plc_index == '0));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
endmodule

bind abuf_admit abuf_admit_chk #(.PORT_W(PORT_W), .IDX_W(IDX_W)) u_admit_chk (
  .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_ok(arr_ok),
  .arr_nobuf(arr_nobuf), .cls_valid(cls_valid), .cls_prio(cls_prio),
  .cls_port(cls_port), .plc_valid(plc_valid), .plc_drop(plc_drop),
  .plc_region(plc_region), .plc_index(plc_index), .err_flag(err_flag));

// File: tb/test_abuf_admit.sv
module test_abuf_admit;
  localparam int CLK_PERIOD = 10;
  localparam int T_TMP = 3, T_SH = 2, T_SLOW = 1, T_CPU = 2, T_GIG = 1;
  localparam int T_CLS0 = 1, T_CLS1 = 2, T_CLS2 = 1;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       arr_valid = 0, cls_valid = 0, free_valid = 0;
  logic [2:0] cls_prio = '0;
  logic [3:0] cls_port = '0, free_index = '0;
  logic [1:0] free_region = '0;
  logic       arr_ok, arr_nobuf, plc_valid, plc_drop, err_flag;
  logic [1:0] plc_region;
  logic [3:0] plc_index;

  always #(CLK_PERIOD/2) clk = ~clk;

  abuf_admit i_abuf_admit (
    .clk(clk), .rst_n(rst_n),
    .cfg_tmp_size(8'(T_TMP)), .cfg_shared_size(8'(T_SH)),
    .cfg_cls_size({8'(T_CLS2), 8'(T_CLS1), 8'(T_CLS0)}),
    .cfg_slow_size(8'(T_SLOW)), .cfg_cpu_size(8'(T_CPU)), .cfg_gig_size(8'(T_GIG)),
    .arr_valid(arr_valid), .arr_ok(arr_ok), .arr_nobuf(arr_nobuf),
    .cls_valid(cls_valid), .cls_prio(cls_prio), .cls_port(cls_port),
    .plc_valid(plc_valid), .plc_drop(plc_drop), .plc_region(plc_region),
    .plc_index(plc_index), .free_valid(free_valid), .free_region(free_region),
    .free_index(free_index), .err_flag(err_flag));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_tmp = 0, m_sh = 0;
  int m_cls[3] = '{0, 0, 0};
  int m_prt[10] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
  bit m_err = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cls_lim(input int k);
    return (k == 0) ? T_CLS0 : (k == 1) ? T_CLS1 : T_CLS2;
  endfunction

  function automatic int prt_lim(input int p);
    return (p == 8) ? T_CPU : (p == 9) ? T_GIG : T_SLOW;
  endfunction

  // Called right after a falling edge; returns right after the next one.
  task automatic step(input bit a, input bit c, input int prio, input int port,
                      input bit f, input int fcode, input int fidx, input string tag);
    int e_arr, e_plc, rg, ix, pair;
    string atag, ptag;
    // free first
    if (f) begin
      if (fcode == 0 && fidx < 3) begin
        if (m_cls[fidx] == 0) m_err = 1; else m_cls[fidx]--;
      end else if (fcode == 1) begin
        if (m_sh == 0) m_err = 1; else m_sh--;
      end else if (fcode == 2 && fidx < 10) begin
        if (m_prt[fidx] == 0) m_err = 1; else m_prt[fidx]--;
      end
    end
    e_plc = 0; rg = 0; ix = 0;
    if (c) begin
      if (m_tmp == 0) m_err = 1; else m_tmp--;
      pair = prio / 2;
      if (pair != 0 && m_cls[pair-1] < cls_lim(pair-1)) begin
        rg = 0; ix = pair - 1; m_cls[pair-1]++;
      end else if (m_sh < T_SH) begin
        rg = 1; m_sh++;
      end else if (port < 10 && m_prt[port] < prt_lim(port)) begin
        rg = 2; ix = port; m_prt[port]++;
      end else rg = 3;
      e_plc = 128 + ((rg == 3) ? 64 : 0) + rg * 16 + ix;
    end
    e_arr = 0;
    if (a) begin
      if (m_tmp < T_TMP) begin e_arr = 2; m_tmp++; end else e_arr = 1;
    end
    atag = (tag != "") ? tag : (c ? "R11" : "R2");
    ptag = (tag != "") ? tag : !c ? "R7" :
           (rg == 0) ? "R3" : (rg == 1) ? "R4" : (rg == 2) ? "R5" : "R6";
    arr_valid = a; cls_valid = c; cls_prio = 3'(prio); cls_port = 4'(port);
    free_valid = f; free_region = 2'(fcode); free_index = 4'(fidx);
    @(posedge clk);
    @(negedge clk);
    arr_valid = 0; cls_valid = 0; free_valid = 0;
    chk(atag, {arr_ok, arr_nobuf}, e_arr);
    chk(ptag, {plc_valid, plc_drop, plc_region, plc_index}, e_plc);
    chk((tag != "") ? tag : "R9", err_flag, m_err);
  endtask

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset and after release
    chk("R1", {arr_ok, arr_nobuf, plc_valid, plc_drop, plc_region, plc_index, err_flag}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {arr_ok, arr_nobuf, plc_valid, plc_drop, plc_region, plc_index, err_flag}, 0);

    // R2: fill the temporary reserve, last arrival refused
    for (int i = 0; i < T_TMP + 1; i++) step(1, 0, 0, 0, 0, 0, 0, "R2");

    // R3..R6, R11: sweep every port and priority, arrival paired with classification
    for (int p = 0; p < 10; p++)
      for (int q = 0; q < 8; q++)
        step(1, 1, q, p, 0, 0, 0, "");

    // R12: ignored frees leave state unchanged and raise no error
    step(0, 0, 0, 0, 1, 3, 0, "R12");
    step(0, 0, 0, 0, 1, 0, 3, "R12");
    step(0, 0, 0, 0, 1, 2, 12, "R12");
    step(1, 1, 7, 9, 0, 0, 0, "R12");
    step(1, 1, 0, 12, 0, 0, 0, "R6");

    // R10: free class 0 and classify priority 3 in the same cycle
    step(1, 1, 3, 0, 1, 0, 0, "R10");

    // R8: return every slot, then reuse one
    for (int k = 0; k < 3; k++) begin
      int n = m_cls[k];
      for (int j = 0; j < n; j++) step(0, 0, 0, 0, 1, 0, k, "R8");
    end
    begin
      int n = m_sh;
      for (int j = 0; j < n; j++) step(0, 0, 0, 0, 1, 1, 0, "R8");
    end
    for (int p = 0; p < 10; p++) begin
      int n = m_prt[p];
      for (int j = 0; j < n; j++) step(0, 0, 0, 0, 1, 2, p, "R8");
    end
    step(1, 1, 0, 3, 0, 0, 0, "R8");

    // R9: free an empty port counter, then show it did not wrap
    step(0, 0, 0, 0, 1, 2, 5, "R9");
    step(1, 1, 0, 5, 0, 0, 0, "R9");
    step(1, 1, 1, 5, 0, 0, 0, "R9");
    step(1, 1, 1, 5, 0, 0, 0, "R9");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule